// File: doc/BRIEF.md
# Cascadable Decimal Digit Counter

This block is one decimal digit of a synchronous counter. On each rising clock edge it can take a 4-bit value from its data input, step to the next digit in the sequence 0 to 9 and back to 0, or keep its value. A low level on the clear input sets the digit to zero at once, with no clock edge needed. Clear comes first, then load, then count or hold.

Counting needs two enables. The first, `cnt_en`, only gates the step. The second, `carry_in`, gates the step and also drives the carry flag `carry_out` through logic alone. `carry_out` is high while the digit holds 9 and `carry_in` is high. To build a multi-digit decimal counter, connect each digit's `carry_out` to the next digit's `carry_in` and drive `cnt_en` and `load_n` to all digits in common. Each upper digit then steps only on the edge where the digits below it roll from 9 to 0.

Codes 10 to 15 can only appear through a load. From such a code the digit steps by plain binary increment, with 15 going to 0, so the next count edge after 15 puts it back in the decimal range. The carry flag never rises for these codes.

Top module: `bcd_decade_counter`

## Requirements
- R1: While `clr_n` is low, `count` is 0 at once, with no clock edge needed, whatever `load_n`, `cnt_en`, `carry_in` and `din` are doing.
- R2: At a rising edge with `clr_n` high and `load_n` low, `count` takes `din`. This holds for every combination of the two enables, both low included.
- R3: At a rising edge with `clr_n`, `load_n`, `cnt_en` and `carry_in` all high and `count` between 0 and 8, `count` increases by one.
- R4: Under the same counting conditions, a `count` of 9 becomes 0.
- R5: At a rising edge with `load_n` high and either enable low, `count` keeps its value.
- R6: `carry_out` is 1 exactly when `carry_in` is 1 and `count` is 9 (binary 1001). It follows `carry_in` between clock edges and does not depend on `cnt_en`.
- R7: Under counting conditions, a loaded code from 10 to 14 steps to that code plus one, and 15 steps to 0. `carry_out` stays 0 for every code from 10 to 15.
- R8: Two digits chained low `carry_out` to high `carry_in`, sharing `cnt_en`, `load_n` and `clr_n`, count decimally from 00 to 99 and wrap to 00. The upper digit steps only on the edge where the lower digit goes from 9 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The digit changes on the rising edge. |
| clr_n | input | 1 | Clear, active low, asynchronous. Sets `count` to 0. |
| load_n | input | 1 | Parallel load, active low, acts at the clock edge. |
| cnt_en | input | 1 | Count enable. Gates the step only. |
| carry_in | input | 1 | Count enable that is also passed on to `carry_out`. |
| din | input | 4 | Value to load. |
| count | output | 4 | Present digit. |
| carry_out | output | 1 | High while `carry_in` is high and `count` is 9. |

## Verification
The 4-bit register is the only state in the block. A wrong state therefore shows up on `count` right after the edge that stored it. It also shows on `carry_out` in the same interval whenever `carry_in` is high. A wrong successor or a wrong priority between load, count and hold is seen one edge after the stimulus. A clear that waited for the clock would be seen before the next edge. A chained upper digit turns a wrong wrap or carry in the lower digit into a wrong second decimal place within ten edges.

// File: rtl/bcd_cnt_pkg.sv
// Package: bcd_cnt_pkg
// Holds the types and constants that all modules of the decimal digit
// counter share.
// Assumes: one digit uses a 4-bit code and the last legal value is 9.
package bcd_cnt_pkg;

    localparam int DIGIT_W_DEF   = 4;
    localparam int LAST_CODE_DEF = 9;

    // Action taken at the next clock edge
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } digit_op_e;

endpackage

// File: rtl/bcd_op_select.sv
// Module: bcd_op_select
// Picks the action for the next clock edge from the control inputs.
// Load comes before count, and count needs both enables.
// Assumes: the asynchronous clear is handled in the register.
module bcd_op_select
    import bcd_cnt_pkg::*;
(
    input  logic      load_n,
    input  logic      cnt_en,
    input  logic      carry_in,
    output digit_op_e op
);

    // Priority decode: load, then count, then hold
    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (cnt_en && carry_in) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/bcd_successor.sv
// Module: bcd_successor
// Gives the value that follows the present digit.
// LAST_CODE goes to 0. Any other code, illegal ones included, goes to
// code plus one, and the all-ones code wraps to 0.
// Assumes: LAST_CODE fits in DIGIT_W bits.
module bcd_successor #(
    parameter int DIGIT_W   = 4,
    parameter int LAST_CODE = 9
) (
    input  logic [DIGIT_W-1:0] cur,
    output logic [DIGIT_W-1:0] nxt
);

    localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(LAST_CODE);

    // Decade wrap at LAST, binary increment everywhere else
    always_comb begin
        if (cur == LAST) begin
            nxt = '0;
        end else begin
            nxt = cur + DIGIT_W'(1);
        end
    end

endmodule

// File: rtl/bcd_digit_reg.sv
// Module: bcd_digit_reg
// Digit register. An asynchronous active-low clear sets it to 0. At the
// clock edge it loads, takes the successor, or holds, as op selects.
// Assumes: op and the inputs to the successor settle before the edge.
module bcd_digit_reg
    import bcd_cnt_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic               clk,
    input  logic               clr_n,
    input  digit_op_e          op,
    input  logic [DIGIT_W-1:0] din,
    input  logic [DIGIT_W-1:0] succ,
    output logic [DIGIT_W-1:0] q
);

    // State update; clear does not wait for the clock
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            case (op)
                OP_LOAD:  q <= din;
                OP_COUNT: q <= succ;
                default:  q <= q;
            endcase
        end
    end

endmodule

// File: rtl/bcd_decade_counter.sv
// Module: bcd_decade_counter
// One cascadable decimal digit with parallel load, two count enables and
// a carry flag that depends on carry_in through logic alone.
// Assumes: in a chain, cnt_en, load_n and clr_n go to all digits, and each
// carry_out feeds the next digit's carry_in.
module bcd_decade_counter
    import bcd_cnt_pkg::*;
#(
    parameter int DIGIT_W   = DIGIT_W_DEF,
    parameter int LAST_CODE = LAST_CODE_DEF
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic               cnt_en,
    input  logic               carry_in,
    input  logic [DIGIT_W-1:0] din,
    output logic [DIGIT_W-1:0] count,
    output logic               carry_out
);

    localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(LAST_CODE);

    digit_op_e          op;
    logic [DIGIT_W-1:0] succ;
    logic [DIGIT_W-1:0] q;

    bcd_op_select u_sel (
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .carry_in (carry_in),
        .op       (op)
    );

    bcd_successor #(
        .DIGIT_W   (DIGIT_W),
        .LAST_CODE (LAST_CODE)
    ) u_succ (
        .cur (q),
        .nxt (succ)
    );

    bcd_digit_reg #(
        .DIGIT_W (DIGIT_W)
    ) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .op    (op),
        .din   (din),
        .succ  (succ),
        .q     (q)
    );

    // Output digit and a look-ahead carry built from logic only
    always_comb begin
        count     = q;
        carry_out = carry_in && (q == LAST);
    end

endmodule

// File: rtl/bcd_decade_counter_chk.sv
// Module: bcd_decade_counter_chk
// Checker for bcd_decade_counter, attached to it with bind.
// It works only from the top-level ports.
module bcd_decade_counter_chk #(
    parameter int DIGIT_W   = 4,
    parameter int LAST_CODE = 9
) (
    input logic               clk,
    input logic               clr_n,
    input logic               load_n,
    input logic               cnt_en,
    input logic               carry_in,
    input logic [DIGIT_W-1:0] din,
    input logic [DIGIT_W-1:0] count,
    input logic               carry_out
);

    localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(LAST_CODE);
    localparam logic [DIGIT_W-1:0] TOP  = '1;

    logic counting;
    assign counting = load_n && cnt_en && carry_in;

    assert_clear_zero_R1: assert property (@(posedge clk)
        !clr_n |-> count == '0);

    assert_load_takes_din_R2: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> count == $past(din));

    assert_step_up_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (counting && count < LAST) |=> count == $past(count) + DIGIT_W'(1));

    assert_decade_wrap_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (counting && count == LAST) |=> count == '0);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(cnt_en && carry_in)) |=> $stable(count));

    assert_carry_needs_nine_R6: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> (carry_in && count == LAST));

    assert_illegal_step_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (counting && count > LAST && count != TOP) |=> count == $past(count) + DIGIT_W'(1));

    assert_illegal_wrap_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (counting && count == TOP) |=> count == '0);

    assert_no_carry_illegal_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (count > LAST) |-> !carry_out);

endmodule

bind bcd_decade_counter bcd_decade_counter_chk #(
    .DIGIT_W   (DIGIT_W),
    .LAST_CODE (LAST_CODE)
) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .cnt_en    (cnt_en),
    .carry_in  (carry_in),
    .din       (din),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/test_bcd_decade_counter.sv
`timescale 1ns/1ps
module test_bcd_decade_counter;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       load_n = 1'b1;
    logic       cnt_en = 1'b0;
    logic       carry_in = 1'b0;
    logic [3:0] din_lo = '0;
    logic [3:0] din_hi = '0;
    logic [3:0] q_lo, q_hi;
    logic       co_lo, co_hi;

    int n_chk = 0;
    int n_fail = 0;
    int m_lo = 0;
    int m_hi = 0;

    always #4 clk = ~clk;

    bcd_decade_counter i_bcd_decade_counter (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .carry_in(carry_in), .din(din_lo), .count(q_lo), .carry_out(co_lo)
    );

    bcd_decade_counter i_bcd_decade_counter_hi (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .carry_in(co_lo), .din(din_hi), .count(q_hi), .carry_out(co_hi)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int nxt(input int q, input bit ld_n, input bit ep, input bit et, input int d);
        if (!ld_n) return d;
        if (!(ep && et)) return q;
        if (q == 9) return 0;
        return (q + 1) % 16;
    endfunction

    function automatic string tag_of(input bit ld_n, input bit ep, input bit et, input int q);
        if (!ld_n) return "R2";
        if (!(ep && et)) return "R5";
        if (q == 9) return "R4";
        if (q > 9) return "R7";
        return "R3";
    endfunction

    // Carry flags against the model, checked between edges
    task automatic chk_carry();
        chk("R6 lo carry", int'(co_lo), int'(carry_in && m_lo == 9));
        chk("R6 hi carry", int'(co_hi), int'(co_lo && m_hi == 9));
    endtask

    // One clock edge: update the model, then sample 2 ns after the edge
    task automatic step();
        string t_lo;
        bit    tc_lo;
        int    n_lo;
        int    n_hi;
        @(posedge clk);
        #2;
        t_lo  = tag_of(load_n, cnt_en, carry_in, m_lo);
        tc_lo = carry_in && (m_lo == 9);
        n_lo  = nxt(m_lo, load_n, cnt_en, carry_in, int'(din_lo));
        n_hi  = nxt(m_hi, load_n, cnt_en, tc_lo, int'(din_hi));
        m_lo  = n_lo;
        m_hi  = n_hi;
        chk(t_lo, int'(q_lo), m_lo);
        chk("R8 upper digit", int'(q_hi), m_hi);
        chk_carry();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Clear is held from time zero
        #1;
        chk("R1 reset lo", int'(q_lo), 0);
        chk("R1 reset hi", int'(q_hi), 0);
        @(negedge clk);
        @(negedge clk);
        clr_n = 1'b1;
        @(negedge clk);

        // Every start code 0..15 against every control combination
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 8; c++) begin
                load_n = 1'b0;
                din_lo = 4'(s);
                din_hi = 4'(15 - s);
                step();
                {load_n, cnt_en, carry_in} = 3'(c);
                din_lo = ~4'(s);
                din_hi = 4'(s);
                step();
            end
        end

        // Load while both enables are low
        cnt_en = 1'b0;
        carry_in = 1'b0;
        load_n = 1'b0;
        din_lo = 4'd6;
        din_hi = 4'd3;
        step();

        // The carry follows carry_in without an edge; cnt_en has no effect
        din_lo = 4'd9;
        step();
        load_n = 1'b1;
        carry_in = 1'b1;
        #1;
        chk("R6 carry rises", int'(co_lo), 1);
        cnt_en = 1'b1;
        #1;
        chk("R6 cnt_en ignored", int'(co_lo), 1);
        cnt_en = 1'b0;
        carry_in = 1'b0;
        #1;
        chk("R6 carry falls", int'(co_lo), 0);
        @(negedge clk);

        // Load seven, then count 8, 9, 0, 1, 2, 3, then stop
        load_n = 1'b0;
        din_lo = 4'd7;
        din_hi = 4'd0;
        step();
        load_n = 1'b1;
        cnt_en = 1'b1;
        carry_in = 1'b1;
        for (int k = 0; k < 6; k++) step();
        chk("R3 seq end", int'(q_lo), 3);
        cnt_en = 1'b0;
        step();
        step();

        // Two-digit run 00 to 99 and back round
        load_n = 1'b0;
        din_lo = 4'd0;
        din_hi = 4'd0;
        step();
        load_n = 1'b1;
        cnt_en = 1'b1;
        carry_in = 1'b1;
        for (int k = 0; k < 105; k++) step();
        chk("R8 decimal value", int'(q_hi) * 10 + int'(q_lo), 5);

        // Asynchronous clear in mid-cycle, which also beats a pending load
        load_n = 1'b0;
        din_lo = 4'd5;
        din_hi = 4'd4;
        step();
        #1;
        clr_n = 1'b0;
        din_lo = 4'd7;
        #1;
        chk("R1 async lo", int'(q_lo), 0);
        chk("R1 async hi", int'(q_hi), 0);
        @(posedge clk);
        #2;
        chk("R1 over load", int'(q_lo), 0);
        @(negedge clk);
        clr_n = 1'b1;
        load_n = 1'b1;
        m_lo = 0;
        m_hi = 0;
        step();
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule